// File: doc/BRIEF.md
# I2C Master Byte Receiver

This block is the receive half of an I2C master. Once the bus has been addressed elsewhere and the engine is idle, a host pulse on `rx_go` makes it clock eight bits in from the slave. A reload counter flips SCL each time it reaches zero. The engine samples SDA on every rising SCL edge, most significant bit first. After the eighth falling edge it parks with SCL driven low, copies the byte into a holding buffer, and raises the buffer-full and interrupt flags.

A second host pulse, `ack_go`, clocks out one acknowledge bit chosen by the host on SDA for one SCL period. The engine then raises the interrupt flag and returns to idle. Both lines are open-drain: an output enable of 1 pulls the line low, and 0 releases it. Sticky overflow and write-collision flags record host timing errors. Start, stop, address transmission, slave clock stretching and arbitration are outside this block.

Top module: `i2c_rx_engine`

## Requirements
- R1: After reset the engine is idle, SCL is driven low (`scl_oe`=1), SDA is released (`sda_oe`=0), and `rx_busy`, `ack_busy`, `buf_full`, `ovf`, `wcol`, `irq` and `rx_data` are all 0.
- R2: An `rx_go` pulse while idle starts a receive. During the receive SDA stays released. SCL toggles every `divisor`+1 clocks, beginning low, and the first toggle comes `divisor`+1 clocks after the start.
- R3: SDA is sampled on each clock where SCL goes from low to high, most significant bit first. The eight samples form the byte shown on `rx_data`.
- R4: At the eighth falling SCL edge, `rx_busy` clears, SCL stays driven low, the byte is copied to `rx_data`, and `buf_full` is set.
- R5: A `buf_rd` pulse clears `buf_full`. If a byte completes in the same cycle as a read, `buf_full` ends up set.
- R6: If a byte completes while `buf_full` is set and no `buf_rd` happens in that cycle, `ovf` is set. The new byte still replaces the buffer. `ovf` stays set until an `ovf_clr` pulse; a set in the same cycle wins over the clear.
- R7: A `buf_wr` pulse during a receive sets `wcol` and leaves `rx_data` unchanged. A `buf_wr` pulse at any other time loads `buf_wdata` into `rx_data`. `wcol` stays set until `wcol_clr`; a set in the same cycle wins over the clear.
- R8: `rx_go` and `ack_go` are ignored unless the engine is idle. If both arrive together while idle, the receive starts.
- R9: An `ack_go` pulse while idle sets `ack_busy` and drives SDA with `ack_bit` (0 = ACK, `sda_oe`=1; 1 = NACK, `sda_oe`=0) for one SCL period (low half, then high half, each `divisor`+1 clocks). At the falling edge that ends the period, `ack_busy` clears and SDA is released.
- R10: `irq` is set when a byte completes and when an acknowledge ends. It stays set until an `irq_clr` pulse; a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | DIV_W | Reload value; SCL half period is divisor+1 clocks |
| rx_go | input | 1 | Pulse: request a byte receive |
| ack_go | input | 1 | Pulse: request an acknowledge bit |
| ack_bit | input | 1 | Acknowledge value, 0 = ACK, 1 = NACK |
| buf_rd | input | 1 | Pulse: host reads the buffer |
| buf_wr | input | 1 | Pulse: host writes the buffer |
| buf_wdata | input | 8 | Data for a host buffer write |
| irq_clr | input | 1 | Pulse: clear interrupt flag |
| ovf_clr | input | 1 | Pulse: clear overflow flag |
| wcol_clr | input | 1 | Pulse: clear write-collision flag |
| sda_in | input | 1 | Sensed SDA level |
| rx_data | output | 8 | Holding buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | Sticky overflow flag |
| wcol | output | 1 | Sticky write-collision flag |
| irq | output | 1 | Interrupt flag |
| rx_busy | output | 1 | Receive in progress (self-clearing enable) |
| ack_busy | output | 1 | Acknowledge in progress (self-clearing enable) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong reload count or a wrong edge counter appears on `scl_oe` within one half period: a toggle comes a cycle early or late, or the eighth falling edge does not stop the clock. A wrong sampling edge or bit order shows up once the byte completes, as a wrong `rx_data` value for a known slave pattern. A flag that takes its old value instead of its new one, or a lost set-over-clear priority, shows up one cycle after the triggering pulse. For that reason every output is compared with an independent model on every clock.

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rx_go,
  input  logic             ack_go,
  input  logic             ack_bit,
  input  logic             buf_rd,
  input  logic             buf_wr,
  input  logic [7:0]       buf_wdata,
  input  logic             irq_clr,
  input  logic             ovf_clr,
  input  logic             wcol_clr,
  input  logic             sda_in,
  output logic [7:0]       rx_data,
  output logic             buf_full,
  output logic             ovf,
  output logic             wcol,
  output logic             irq,
  output logic             rx_busy,
  output logic             ack_busy,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int EDGES = 16;
  localparam int EW    = $clog2(EDGES + 1);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK} state_t;

  state_t           st;
  logic [DIV_W-1:0] cnt;
  logic [EW-1:0]    nedge;
  logic [7:0]       shreg;
  logic             scl_low, sda_low;

  wire roll     = (st != S_IDLE) && (cnt == '0);
  wire rx_done  = (st == S_RX)  && roll && !scl_low && (nedge == EW'(EDGES - 1));
  wire ack_done = (st == S_ACK) && roll && !scl_low;

  assign rx_busy  = (st == S_RX);
  assign ack_busy = (st == S_ACK);
  assign scl_oe   = scl_low;
  assign sda_oe   = sda_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      nedge   <= '0;
      shreg   <= '0;
      scl_low <= 1'b1;
      sda_low <= 1'b0;
    end else if (st == S_IDLE) begin
      if (rx_go) begin
        st      <= S_RX;
        cnt     <= divisor;
        nedge   <= '0;
        scl_low <= 1'b1;
        sda_low <= 1'b0;
      end else if (ack_go) begin
        st      <= S_ACK;
        cnt     <= divisor;
        nedge   <= '0;
        scl_low <= 1'b1;
        sda_low <= ~ack_bit;
      end
    end else if (roll) begin
      cnt     <= divisor;
      scl_low <= ~scl_low;
      nedge   <= nedge + 1'b1;
      if (st == S_RX && scl_low) shreg <= {shreg[6:0], sda_in};
      if (rx_done) st <= S_IDLE;
      if (ack_done) begin
        st      <= S_IDLE;
        sda_low <= 1'b0;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      buf_full <= 1'b0;
      ovf      <= 1'b0;
      wcol     <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (rx_done) rx_data <= shreg;
      else if (buf_wr && st != S_RX) rx_data <= buf_wdata;

      if (rx_done) buf_full <= 1'b1;
      else if (buf_rd) buf_full <= 1'b0;

      if (rx_done && buf_full && !buf_rd) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;

      if (buf_wr && st == S_RX) wcol <= 1'b1;
      else if (wcol_clr) wcol <= 1'b0;

      if (rx_done || ack_done) irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  p_rx_sda_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> !sda_oe);
  p_byte_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_busy) |-> (buf_full && irq && scl_oe));
  p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && buf_full && !buf_rd) |=> ovf);
  p_wcol_keeps_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && buf_wr && !rx_done) |=> (wcol && $stable(rx_data)));
  p_busy_ignores_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && rx_go && !rx_done) |=> rx_busy);
  p_one_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_busy && ack_busy));
  p_ack_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_busy) |-> (irq && !sda_oe && scl_oe));
endmodule

// File: tb/i2c_rx_engine_bench.sv
module i2c_rx_engine_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] divisor = 8'd2;
  logic rx_go = 0, ack_go = 0, ack_bit = 0, buf_rd = 0, buf_wr = 0;
  logic [7:0] buf_wdata = 0;
  logic irq_clr = 0, ovf_clr = 0, wcol_clr = 0, sda_in = 1;
  logic [7:0] rx_data;
  logic buf_full, ovf, wcol, irq, rx_busy, ack_busy, scl_oe, sda_oe;

  always #2.5 clk = ~clk;

  i2c_rx_engine #(.DIV_W(8)) u_i2c_rx_engine (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .rx_go(rx_go), .ack_go(ack_go),
    .ack_bit(ack_bit), .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .wcol_clr(wcol_clr), .sda_in(sda_in),
    .rx_data(rx_data), .buf_full(buf_full), .ovf(ovf), .wcol(wcol), .irq(irq),
    .rx_busy(rx_busy), .ack_busy(ack_busy), .scl_oe(scl_oe), .sda_oe(sda_oe));

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;
  logic [7:0] slave_byte = 8'h00;

  // reference model: 0 idle, 1 receive, 2 acknowledge
  int m_st = 0, m_tick = 0, m_edges = 0, m_sh = 0, m_buf = 0;
  int m_full = 0, m_ovf = 0, m_wcol = 0, m_irq = 0, m_scl_low = 1, m_sda_low = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_tick = 0; m_edges = 0; m_sh = 0; m_buf = 0; m_full = 0;
      m_ovf = 0; m_wcol = 0; m_irq = 0; m_scl_low = 1; m_sda_low = 0;
    end else begin
      bit roll, rdone, adone;
      roll  = (m_st != 0) && (m_tick == 0);
      rdone = (m_st == 1) && roll && (m_edges == 15);
      adone = (m_st == 2) && roll && (m_edges == 1);
      if (rdone && m_full == 1 && !buf_rd) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (m_st == 1 && buf_wr) m_wcol = 1; else if (wcol_clr) m_wcol = 0;
      if (rdone || adone) m_irq = 1; else if (irq_clr) m_irq = 0;
      if (rdone) m_full = 1; else if (buf_rd) m_full = 0;
      if (rdone) m_buf = m_sh; else if (buf_wr && m_st != 1) m_buf = buf_wdata;
      if (m_st == 0) begin
        if (rx_go) begin m_st = 1; m_tick = divisor; m_edges = 0; m_scl_low = 1; m_sda_low = 0; end
        else if (ack_go) begin m_st = 2; m_tick = divisor; m_edges = 0; m_scl_low = 1; m_sda_low = ack_bit ? 0 : 1; end
      end else if (roll) begin
        if (m_st == 1 && m_scl_low == 1) m_sh = ((m_sh << 1) | sda_in) & 255;
        m_scl_low = 1 - m_scl_low;
        m_edges++;
        m_tick = divisor;
        if (rdone) m_st = 0;
        if (adone) begin m_st = 0; m_sda_low = 0; end
      end else m_tick--;
    end
  end

  always @(negedge clk) begin
    if (m_st == 1 && m_edges < 16) sda_in <= slave_byte[7 - m_edges / 2];
    else sda_in <= 1'b1;
    if (rst_n && !finished) begin
      chk("R2", "scl_oe", scl_oe, m_scl_low);
      chk("R9", "sda_oe", sda_oe, m_sda_low);
      chk("R3", "rx_data", rx_data, m_buf);
      chk("R5", "buf_full", buf_full, m_full);
      chk("R6", "ovf", ovf, m_ovf);
      chk("R7", "wcol", wcol, m_wcol);
      chk("R10", "irq", irq, m_irq);
      chk("R4", "rx_busy", rx_busy, m_st == 1);
      chk("R9", "ack_busy", ack_busy, m_st == 2);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(); s = 0;
  endtask

  task automatic receive(input logic [7:0] b);
    slave_byte = b;
    pulse(rx_go);
    while (rx_busy && !finished) tick();
    tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    tick(3);
    chk("R1", "reset scl_oe", scl_oe, 1);
    chk("R1", "reset flags", {rx_busy, ack_busy, buf_full, ovf, wcol, irq, sda_oe}, 0);
    chk("R1", "reset rx_data", rx_data, 0);
    rst_n = 1; tick();
    receive(8'hA5);
    chk("R3", "first byte", rx_data, 8'hA5);
    chk("R4", "full after byte", buf_full, 1);
    buf_rd = 1; irq_clr = 1; tick(); buf_rd = 0; irq_clr = 0; tick();
    chk("R5", "full cleared by read", buf_full, 0);
    receive(8'h3C);
    receive(8'h5A);
    chk("R6", "overflow set", ovf, 1);
    chk("R6", "overflow byte replaces", rx_data, 8'h5A);
    pulse(ovf_clr); tick();
    chk("R6", "overflow cleared", ovf, 0);
    divisor = 8'd3; buf_rd = 1; tick(); buf_rd = 0;
    slave_byte = 8'hC3; pulse(rx_go); tick(5);
    buf_wdata = 8'hEE; pulse(buf_wr); tick();
    chk("R7", "write collision", wcol, 1);
    chk("R7", "buffer unchanged", rx_data, 8'h5A);
    pulse(rx_go); pulse(ack_go); tick(2);
    while (rx_busy) tick();
    tick();
    chk("R8", "byte after ignored requests", rx_data, 8'hC3);
    chk("R8", "no ack started", ack_busy, 0);
    pulse(wcol_clr);
    buf_wdata = 8'h11; pulse(buf_wr); tick();
    chk("R7", "idle write loads", rx_data, 8'h11);
    ack_bit = 0; pulse(ack_go); tick();
    chk("R9", "ack drives low", sda_oe, 1);
    pulse(rx_go);
    while (ack_busy) tick();
    chk("R9", "ack released", sda_oe, 0);
    chk("R8", "rx ignored during ack", rx_busy, 0);
    ack_bit = 1; pulse(ack_go); tick();
    chk("R9", "nack releases", sda_oe, 0);
    while (ack_busy) tick();
    divisor = 8'd0; buf_rd = 1; tick(); buf_rd = 0;
    slave_byte = 8'h81; pulse(rx_go);
    while (rx_busy) begin
      if (!scl_oe) begin irq_clr = 1; end
      tick(); irq_clr = 0;
    end
    tick();
    chk("R10", "set wins over clear", irq, 1);
    chk("R3", "fast divisor byte", rx_data, 8'h81);
    rx_go = 1; ack_go = 1; tick(); rx_go = 0; ack_go = 0; tick();
    chk("R8", "rx wins tie", rx_busy, 1);
    while (rx_busy) tick();
    divisor = 8'd5; buf_rd = 1; tick(); buf_rd = 0;
    receive(8'h7E);
    chk("R3", "slow divisor byte", rx_data, 8'h7E);
    tick(4);
    finish_run();
  end

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    finish_run();
  end
endmodule